// File: doc/BRIEF.md
# EDO DRAM Write-Cycle Sequencer

This block drives the control strobes of an EDO DRAM for one write access. A requester presents a two-bit cycle code and a data word. The block lowers the row strobe, then runs one of three write shapes: an early write, a delayed write or a read-modify-write. Every interval between strobe edges is a parameter counted in clock cycles. The block also switches the controller's data-bus drive enable.

In an early write, the write strobe is low before the column strobe falls, and the column strobe edge latches the data. In a delayed write, the column strobe falls first and the write strobe edge latches the data. A read-modify-write first reads the addressed cell with the output enable low. It waits the longest of the three access times before it captures the bus. It then raises the output enable and turns the bus drive on only after the DRAM output has had time to go quiet, and it finishes with a write-strobe-referenced write.

At the end of every access, the row strobe, column strobe, write strobe and bus drive are all released on the same edge. A one-clock acknowledge marks the cycle in which the row strobe rises. A fixed precharge interval follows before the next request can be accepted.

Top module: `edo_wr_seq`

## Requirements
- R1: During and after synchronous reset, ras_n, cas_n, we_n and oe_n are 1, dq_oe is 0 and req_ack is 0.
- R2: A request is accepted on a clock edge where the block is idle and req_valid is 1. req_kind 2'b00 selects an early write, 2'b01 a delayed write and 2'b10 a read-modify-write. Code 2'b11 is ignored: no strobe moves and no acknowledge follows.
- R3: ras_n falls in the cycle after the accepting edge, and cas_n falls T_RCD cycles after ras_n.
- R4: In an early write, we_n falls and dq_oe rises together T_RCD cycles after ras_n falls. cas_n falls T_DS cycles later, and oe_n stays 1 for the whole access.
- R5: In a delayed write, cas_n falls first. dq_oe rises T_CWD cycles after that, we_n falls T_DS cycles after dq_oe rises, and oe_n stays 1 for the whole access.
- R6: In a read-modify-write, oe_n falls together with cas_n and stays 0 for exactly max(T_AA, T_CAC, T_CPA) cycles. rd_data takes the value dq_in holds in the last of those cycles.
- R7: dq_oe and a low oe_n are never active in the same cycle. dq_oe rises only after oe_n has been 1 for at least T_OEZ cycles, with T_OEZ of at least 1. In a read-modify-write, dq_oe rises exactly T_OEZ cycles after oe_n rises, and we_n falls T_DS cycles after that.
- R8: The latching strobe edge (cas_n in an early write, we_n otherwise) is held T_DH cycles. ras_n, cas_n, we_n and dq_oe are then released in the same cycle.
- R9: req_ack is 1 for exactly one cycle, the cycle in which ras_n returns to 1. With a request waiting, ras_n falls again exactly T_RP+1 cycles after it rose.
- R10: While dq_oe is 1, dq_out equals the wr_data sampled at the accepting edge.
- R11: A req_valid presented while an access or its precharge is in progress is ignored and starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_kind | input | 2 | Cycle code: 00 early, 01 delayed, 10 read-modify-write |
| wr_data | input | DW | Write word, sampled on acceptance |
| req_ack | output | 1 | One-clock pulse as the row strobe rises |
| rd_data | output | DW | Word read during a read-modify-write |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| dq_oe | output | 1 | Controller data-bus drive enable |
| dq_out | output | DW | Data driven onto the bus |
| dq_in | input | DW | Data read from the bus |

## Verification
Every strobe is registered, so ras_n moves in the cycle after the accepting edge. Each later edge is due a fixed number of cycles after the ras_n fall, namely the sum of the phase lengths that come before it. The bench samples every output at the falling clock edge and stamps each strobe transition with a cycle count. Each check compares the difference between two stamps with the sum of phase parameters that the requirement gives. The bench's DRAM model supplies valid read data only once oe_n and cas_n have both been low for the full access window, so a capture one cycle early reads the wrong word.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;
  typedef enum logic [1:0] {
    K_EARLY   = 2'b00,
    K_DELAYED = 2'b01,
    K_RMW     = 2'b10,
    K_NONE    = 2'b11
  } wr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_WSET, S_COL, S_OEOFF, S_DSET, S_WLO, S_PRE
  } seq_state_e;
endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/edo_dq_path.sv
module edo_dq_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out  <= '0;
      rd_data <= '0;
    end else begin
      if (accept)  dq_out  <= wr_data;
      if (capture) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/edo_seq_ctrl.sv
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int CW    = 4,
  parameter int T_RCD = 2,
  parameter int T_DS  = 2,
  parameter int T_DH  = 2,
  parameter int T_CWD = 2,
  parameter int T_ACC = 4,
  parameter int T_OEZ = 1,
  parameter int T_RP  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          done,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          capture,
  output logic          req_ack,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);
  seq_state_e state, state_nxt;
  wr_kind_e   kind, kind_nxt;

  function automatic int phase_len(seq_state_e s, wr_kind_e k);
    case (s)
      S_ROW:   return T_RCD;
      S_WSET:  return T_DS;
      S_COL:   return (k == K_EARLY) ? T_DH : ((k == K_RMW) ? T_ACC : T_CWD);
      S_OEOFF: return T_OEZ;
      S_DSET:  return T_DS;
      S_WLO:   return T_DH;
      S_PRE:   return T_RP;
      default: return 1;
    endcase
  endfunction

  assign accept  = (state == S_IDLE) && req_valid && (req_kind != K_NONE);
  assign capture = (state == S_COL) && (kind == K_RMW) && done;

  always_comb begin
    state_nxt = state;
    kind_nxt  = kind;
    case (state)
      S_IDLE: if (accept) begin
        state_nxt = S_ROW;
        kind_nxt  = wr_kind_e'(req_kind);
      end
      S_ROW:   if (done) state_nxt = (kind == K_EARLY) ? S_WSET : S_COL;
      S_WSET:  if (done) state_nxt = S_COL;
      S_COL:   if (done) state_nxt = (kind == K_EARLY) ? S_PRE :
                                     ((kind == K_RMW) ? S_OEOFF : S_DSET);
      S_OEOFF: if (done) state_nxt = S_DSET;
      S_DSET:  if (done) state_nxt = S_WLO;
      S_WLO:   if (done) state_nxt = S_PRE;
      S_PRE:   if (done) state_nxt = S_IDLE;
      default: state_nxt = S_IDLE;
    endcase
  end

  assign load     = (state_nxt != state);
  assign load_val = CW'(phase_len(state_nxt, kind_nxt) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      kind    <= K_EARLY;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      req_ack <= 1'b0;
    end else begin
      state   <= state_nxt;
      kind    <= kind_nxt;
      ras_n   <= !(state_nxt inside {S_ROW, S_WSET, S_COL, S_OEOFF, S_DSET, S_WLO});
      cas_n   <= !(state_nxt inside {S_COL, S_OEOFF, S_DSET, S_WLO});
      we_n    <= !((state_nxt == S_WSET) || (state_nxt == S_WLO) ||
                   ((state_nxt == S_COL) && (kind_nxt == K_EARLY)));
      oe_n    <= !((state_nxt == S_COL) && (kind_nxt == K_RMW));
      dq_oe   <= (state_nxt == S_WSET) || (state_nxt == S_DSET) || (state_nxt == S_WLO) ||
                 ((state_nxt == S_COL) && (kind_nxt == K_EARLY));
      req_ack <= (state_nxt == S_PRE) && (state != S_PRE);
    end
  end
endmodule

// File: rtl/edo_wr_seq.sv
module edo_wr_seq #(
  parameter int DW    = 16,
  parameter int T_RCD = 2,
  parameter int T_DS  = 2,
  parameter int T_DH  = 2,
  parameter int T_CWD = 2,
  parameter int T_AA  = 3,
  parameter int T_CAC = 2,
  parameter int T_CPA = 4,
  parameter int T_OEZ = 1,
  parameter int T_RP  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] wr_data,
  output logic          req_ack,
  output logic [DW-1:0] rd_data,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  input  logic [DW-1:0] dq_in
);
  localparam int T_AC2 = (T_AA > T_CAC) ? T_AA : T_CAC;
  localparam int T_ACC = (T_AC2 > T_CPA) ? T_AC2 : T_CPA;
  localparam int T_M1  = (T_RCD > T_DS) ? T_RCD : T_DS;
  localparam int T_M2  = (T_DH > T_CWD) ? T_DH : T_CWD;
  localparam int T_M3  = (T_OEZ > T_RP) ? T_OEZ : T_RP;
  localparam int T_M4  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_M5  = (T_M3 > T_ACC) ? T_M3 : T_ACC;
  localparam int T_MAX = (T_M4 > T_M5) ? T_M4 : T_M5;
  localparam int CW    = $clog2(T_MAX + 1);

  logic          load, done, accept, capture;
  logic [CW-1:0] load_val;

  edo_seq_ctrl #(
    .CW(CW), .T_RCD(T_RCD), .T_DS(T_DS), .T_DH(T_DH), .T_CWD(T_CWD),
    .T_ACC(T_ACC), .T_OEZ(T_OEZ), .T_RP(T_RP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .done(done), .load(load), .load_val(load_val), .accept(accept),
    .capture(capture), .req_ack(req_ack), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe)
  );

  edo_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(done)
  );

  edo_dq_path #(.DW(DW)) u_dq (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .wr_data(wr_data), .dq_in(dq_in), .dq_out(dq_out), .rd_data(rd_data)
  );
endmodule

// File: rtl/edo_wr_seq_chk.sv
module edo_wr_seq_chk (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ack
);
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (ras_n && cas_n && we_n && oe_n && !dq_oe && !req_ack)); // R1
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R3
  AST_EARLY_WE_FIRST: assert property (@(posedge clk) disable iff (rst) ($fell(cas_n) && !we_n) |-> $past(!we_n)); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst) dq_oe |-> oe_n); // R7
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (rst) $rose(dq_oe) |-> $past(oe_n)); // R7
  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(ras_n) |-> (cas_n && we_n && !dq_oe)); // R8
  AST_ACK_AT_RAS_RISE: assert property (@(posedge clk) disable iff (rst) req_ack |-> $rose(ras_n)); // R9
  AST_RAS_RISE_ACKS: assert property (@(posedge clk) disable iff (rst) $rose(ras_n) |-> req_ack); // R9
endmodule

bind edo_wr_seq edo_wr_seq_chk u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .req_ack(req_ack)
);

// File: tb/test_edo_wr_seq.sv
`timescale 1ns/1ps
module test_edo_wr_seq;
  localparam int DW = 16;
  localparam int T_RCD = 2, T_DS = 2, T_DH = 2, T_CWD = 2;
  localparam int T_AA = 3, T_CAC = 2, T_CPA = 4, T_OEZ = 1, T_RP = 2;
  localparam int T_ACC = 4; // longest of the three access times

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [DW-1:0] wr_data = '0, dq_in = '0, rd_data, dq_out;
  logic req_ack, ras_n, cas_n, we_n, oe_n, dq_oe;

  always #5 clk = ~clk;

  edo_wr_seq #(.DW(DW), .T_RCD(T_RCD), .T_DS(T_DS), .T_DH(T_DH), .T_CWD(T_CWD),
    .T_AA(T_AA), .T_CAC(T_CAC), .T_CPA(T_CPA), .T_OEZ(T_OEZ), .T_RP(T_RP)) i_edo_wr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .wr_data(wr_data),
    .req_ack(req_ack), .rd_data(rd_data), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in));

  int checks = 0, failures = 0;
  int cyc = 0;
  int t_ras, t_cas, t_we, t_oef, t_oer, t_drv, t_end, t_ack;
  int ack_cnt = 0, ras_cnt = 0, acc_cnt = 0, data_err = 0, oe_drv_clash = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, p_drv = 0;
  logic [DW-1:0] exp_w = '0, rd_good = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // negedge monitor and DRAM read model
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (p_ras && !ras_n) begin t_ras = cyc; ras_cnt++; end
    if (p_cas && !cas_n) t_cas = cyc;
    if (p_we && !we_n)   t_we = cyc;
    if (p_oe && !oe_n)   t_oef = cyc;
    if (!p_oe && oe_n)   t_oer = cyc;
    if (!p_drv && dq_oe) t_drv = cyc;
    if (!p_ras && ras_n) t_end = cyc;
    if (req_ack) begin t_ack = cyc; ack_cnt++; end
    if (dq_oe && dq_out != exp_w) data_err++;
    if (dq_oe && !oe_n) oe_drv_clash++;
    if (!cas_n && !oe_n) acc_cnt++; else acc_cnt = 0;
    dq_in = (acc_cnt >= T_ACC) ? rd_good : ~rd_good;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_drv = dq_oe;
  end

  task automatic clear_marks();
    t_ras = -1; t_cas = -1; t_we = -1; t_oef = -1; t_oer = -1;
    t_drv = -1; t_end = -1; t_ack = -1;
  endtask

  // issue one request and wait for its acknowledge; returns cycle of issue
  task automatic issue(input logic [1:0] k, input logic [DW-1:0] d, output int t_req);
    int a0;
    int n;
    a0 = ack_cnt;
    clear_marks();
    exp_w = d;
    @(negedge clk); #1;
    t_req = cyc; req_valid = 1'b1; req_kind = k; wr_data = d;
    @(negedge clk); #1;
    req_valid = 1'b0; wr_data = ~d;
    n = 0;
    while (ack_cnt == a0 && n < 100) begin @(negedge clk); #1; n++; end
    chk(ack_cnt == a0 + 1, "R9 ack_count", ack_cnt - a0, 1);
    @(negedge clk); #1;
    chk(ack_cnt == a0 + 1, "R9 ack_one_cycle", ack_cnt - a0, 1);
  endtask

  task automatic t_reset();
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes_high", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !req_ack, "R1 drive_ack_low", {dq_oe, req_ack}, 0);
  endtask

  task automatic t_early(input logic [DW-1:0] d);
    int tr;
    issue(2'b00, d, tr);
    chk(t_ras == tr + 1, "R3 early ras_fall", t_ras, tr + 1);
    chk(t_we == t_ras + T_RCD, "R4 early we_fall", t_we, t_ras + T_RCD);
    chk(t_drv == t_ras + T_RCD, "R4 early drive_on", t_drv, t_ras + T_RCD);
    chk(t_cas == t_ras + T_RCD + T_DS, "R4 early cas_fall", t_cas, t_ras + T_RCD + T_DS);
    chk(t_oef == -1, "R4 early oe_high", t_oef, -1);
    chk(t_end == t_cas + T_DH, "R8 early release", t_end, t_cas + T_DH);
    chk(t_ack == t_end, "R9 early ack_at_ras_rise", t_ack, t_end);
  endtask

  task automatic t_delayed(input logic [DW-1:0] d);
    int tr;
    issue(2'b01, d, tr);
    chk(t_cas == t_ras + T_RCD, "R3 delayed cas_fall", t_cas, t_ras + T_RCD);
    chk(t_drv == t_cas + T_CWD, "R5 delayed drive_on", t_drv, t_cas + T_CWD);
    chk(t_we == t_drv + T_DS, "R5 delayed we_fall", t_we, t_drv + T_DS);
    chk(t_oef == -1, "R5 delayed oe_high", t_oef, -1);
    chk(t_end == t_we + T_DH, "R8 delayed release", t_end, t_we + T_DH);
    chk(t_ack == t_end, "R9 delayed ack_at_ras_rise", t_ack, t_end);
  endtask

  task automatic t_rmw(input logic [DW-1:0] d, input logic [DW-1:0] r);
    int tr;
    rd_good = r;
    issue(2'b10, d, tr);
    chk(t_oef == t_cas, "R6 rmw oe_with_cas", t_oef, t_cas);
    chk(t_oer == t_oef + T_ACC, "R6 rmw oe_window", t_oer, t_oef + T_ACC);
    chk(rd_data == r, "R6 rmw rd_data", rd_data, r);
    chk(t_drv == t_oer + T_OEZ, "R7 rmw drive_after_oe", t_drv, t_oer + T_OEZ);
    chk(t_we == t_drv + T_DS, "R7 rmw we_fall", t_we, t_drv + T_DS);
    chk(t_end == t_we + T_DH, "R8 rmw release", t_end, t_we + T_DH);
  endtask

  task automatic t_reserved();
    int r0, a0;
    r0 = ras_cnt; a0 = ack_cnt;
    @(negedge clk); #1; req_valid = 1'b1; req_kind = 2'b11;
    @(negedge clk); #1; req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(ras_cnt == r0, "R2 code11 no_ras", ras_cnt - r0, 0);
    chk(ack_cnt == a0, "R2 code11 no_ack", ack_cnt - a0, 0);
  endtask

  task automatic t_busy_ignore();
    int r0;
    int n;
    r0 = ras_cnt; clear_marks(); exp_w = 16'h0F0F;
    @(negedge clk); #1; req_valid = 1'b1; req_kind = 2'b00; wr_data = 16'h0F0F;
    @(negedge clk); #1; req_valid = 1'b0;
    @(negedge clk); #1; req_valid = 1'b1; req_kind = 2'b01; wr_data = 16'hDEAD;
    n = 0;
    while (t_ack == -1 && n < 100) begin @(negedge clk); #1; n++; end
    @(negedge clk); #1; req_valid = 1'b0;
    repeat (T_RP + 6) @(negedge clk);
    chk(ras_cnt == r0 + 1, "R11 busy_req_ignored", ras_cnt - r0, 1);
  endtask

  task automatic t_back_to_back();
    int n;
    clear_marks(); exp_w = 16'h1357;
    @(negedge clk); #1; req_valid = 1'b1; req_kind = 2'b00; wr_data = 16'h1357;
    n = 0;
    while (t_end == -1 && n < 100) begin @(negedge clk); #1; n++; end
    n = t_end; t_ras = -1;
    while (t_ras == -1 && (cyc - n) < 20) begin @(negedge clk); #1; end
    req_valid = 1'b0;
    chk(t_ras == n + T_RP + 1, "R9 precharge_gap", t_ras - n, T_RP + 1);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    #1 rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_early(16'hA5C3);
    t_delayed(16'h3C96);
    t_rmw(16'h7E81, 16'hB00B);
    t_rmw(16'h0001, 16'h4D2A);
    t_early(16'hFFFF);
    t_reserved();
    t_busy_ignore();
    t_back_to_back();
    chk(data_err == 0, "R10 dq_out_matches_wr_data", data_err, 0);
    chk(oe_drv_clash == 0, "R7 no_drive_with_oe_low", oe_drv_clash, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule